// File: doc/BRIEF.md
# Audio Interface Clock Generator

This block takes the 256fs master clock of an audio subsystem (11.2896 MHz for a 44.1 kHz sample rate) and derives the clocks that leave the chip for external converters and serial audio devices. It drives a frame (left/right) clock and a bit clock from a shared 256-cycle frame counter. It also drives a master-clock output at the input rate or at half of it. A separate programmable divider supplies a divided clock, and its ratio code mixes powers of two with divide-by-3 and divide-by-6.

All configuration inputs are plain level controls. Changes to the frame/bit clock selection, to its enable and to the master-clock output settings are held back until the next frame boundary, so no output ever produces a shortened pulse. A new divider code is taken when the divider finishes its current output period. The only status output is a flag that marks the one code with no defined ratio.

Top module: `audio_clk_gen`

## Requirements
- R1: While reset is asserted and until the first frame boundary after it, the frame clock, bit clock and master-clock output are low. The divider runs at ratio 1 and its error flag is low.
- R2: Rate code `lrb_mode` sets the frame/bit clock pair in periods of the input clock: 0 gives 256/8, 1 gives 256/4, 2 gives 128/4 and 3 gives 128/2. In frame-cycle terms n (0..255) the frame clock is n[7] for codes 0 and 1 and n[6] for codes 2 and 3. The bit clock is n[2], n[1], n[1] or n[0] for codes 0 to 3.
- R3: With the latched `lrb_en` at 0, the frame and bit clocks are both held low.
- R4: The frame clock changes level only on a cycle where the bit clock falls.
- R5: `lrb_en`, `lrb_mode`, `mck_en` and `mck_half` are sampled only at the edge that starts a frame (every 256 input cycles after reset). At that edge the frame and bit clocks are both low.
- R6: With the latched `mck_en` at 1, `mck_out` follows the input clock when `mck_half` is 0. When `mck_half` is 1 it is a half-rate clock that is low at each frame start. With the latched `mck_en` at 0 it is low.
- R7: `div_code` selects the divider ratio: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8, 4 gives /16, 5 gives /3 and 6 gives /6. At /1 the divided clock follows the input clock.
- R8: For ratio R > 1, `div_clk` is high for ceil(R/2) input cycles and then low for floor(R/2) cycles in each period.
- R9: Code 7 is treated as ratio 1. `div_err` is high in the cycle after an edge that sampled code 7, and low after an edge that sampled any other code.
- R10: A new `div_code` takes effect only at the edge that starts a divider period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 256fs master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrb_en | input | 1 | Frame/bit clock output enable |
| lrb_mode | input | 2 | Frame/bit rate code |
| mck_en | input | 1 | Master-clock output enable |
| mck_half | input | 1 | Master-clock output at half rate |
| div_code | input | 3 | Divider ratio code |
| lr_out | output | 1 | Frame (left/right) clock |
| bck_out | output | 1 | Bit clock |
| mck_out | output | 1 | Master-clock output |
| div_clk | output | 1 | Divided clock |
| div_err | output | 1 | Undefined divider code seen |

## Verification
On every cycle, the assertions check three things: the frame clock moves only together with a falling bit clock, both clocks are low at each frame start, and the error flag follows the sampled code. The frame-boundary deferral of configuration, the exact rate table, the master-clock shapes in both clock phases, and the divider duty cycle and period-end code pickup can be shown only by the bench's sweeps. The bench compares those against a cycle-by-cycle arithmetic model.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  localparam int FRAME_CYC = 256;
  localparam int FRAME_W   = $clog2(FRAME_CYC);
  localparam int RATIO_W   = 5;

  // Divider code to ratio; the undefined code falls back to 1.
  function automatic logic [RATIO_W-1:0] code_ratio(input logic [2:0] code);
    case (code)
      3'd1:    code_ratio = RATIO_W'(2);
      3'd2:    code_ratio = RATIO_W'(4);
      3'd3:    code_ratio = RATIO_W'(8);
      3'd4:    code_ratio = RATIO_W'(16);
      3'd5:    code_ratio = RATIO_W'(3);
      3'd6:    code_ratio = RATIO_W'(6);
      default: code_ratio = RATIO_W'(1);
    endcase
  endfunction

  // Frame-counter bit that forms the bit clock for each rate code.
  function automatic int bck_bit(input logic [1:0] mode);
    case (mode)
      2'd0:    bck_bit = FRAME_W - 6;
      2'd3:    bck_bit = FRAME_W - 8;
      default: bck_bit = FRAME_W - 7;
    endcase
  endfunction
endpackage

// File: rtl/lrb_frame_gen.sv
module lrb_frame_gen
  import audio_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  output logic       lr,
  output logic       bck,
  output logic       wrap
);
  logic [FRAME_W-1:0] cnt, cnt_nx;
  logic               en_act, en_use;
  logic [1:0]         mode_act, mode_use;
  logic               lr_d, bck_d;

  assign wrap     = &cnt;
  assign cnt_nx   = cnt + 1'b1;
  assign en_use   = wrap ? en   : en_act;
  assign mode_use = wrap ? mode : mode_act;

  always_comb begin
    lr_d  = en_use & (mode_use[1] ? cnt_nx[FRAME_W-2] : cnt_nx[FRAME_W-1]);
    bck_d = en_use & cnt_nx[bck_bit(mode_use)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      en_act   <= 1'b0;
      mode_act <= 2'd0;
      lr       <= 1'b0;
      bck      <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      en_act   <= en_use;
      mode_act <= mode_use;
      lr       <= lr_d;
      bck      <= bck_d;
    end
  end
endmodule

// File: rtl/mck_out_gen.sv
module mck_out_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic en,
  input  logic half_sel,
  output logic mck
);
  logic half_q, en_act, sel_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      en_act  <= 1'b0;
      sel_act <= 1'b0;
    end else begin
      half_q <= ~half_q;
      if (wrap) begin
        en_act  <= en;
        sel_act <= half_sel;
      end
    end
  end

  assign mck = en_act & (sel_act ? half_q : clk);
endmodule

// File: rtl/ratio_div.sv
module ratio_div
  import audio_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  output logic       div_clk,
  output logic       err
);
  logic [RATIO_W-1:0] r_act, r_use, dc, dc_nx;
  logic [RATIO_W:0]   hi_len;
  logic               at_end, dq;

  assign at_end = ({1'b0, dc} + 1'b1) >= {1'b0, r_act};
  assign r_use  = at_end ? code_ratio(code) : r_act;
  assign dc_nx  = at_end ? '0 : dc + 1'b1;
  assign hi_len = ({1'b0, r_use} + 1'b1) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_act <= RATIO_W'(1);
      dc    <= '0;
      dq    <= 1'b1;
      err   <= 1'b0;
    end else begin
      r_act <= r_use;
      dc    <= dc_nx;
      dq    <= {1'b0, dc_nx} < hi_len;
      err   <= (code == 3'd7);
    end
  end

  assign div_clk = (r_act == RATIO_W'(1)) ? clk : dq;
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrb_en,
  input  logic [1:0] lrb_mode,
  input  logic       mck_en,
  input  logic       mck_half,
  input  logic [2:0] div_code,
  output logic       lr_out,
  output logic       bck_out,
  output logic       mck_out,
  output logic       div_clk,
  output logic       div_err
);
  logic frame_wrap;

  lrb_frame_gen u_frame (
    .clk(clk), .rst_n(rst_n), .en(lrb_en), .mode(lrb_mode),
    .lr(lr_out), .bck(bck_out), .wrap(frame_wrap)
  );

  mck_out_gen u_mck (
    .clk(clk), .rst_n(rst_n), .wrap(frame_wrap), .en(mck_en),
    .half_sel(mck_half), .mck(mck_out)
  );

  ratio_div u_div (
    .clk(clk), .rst_n(rst_n), .code(div_code),
    .div_clk(div_clk), .err(div_err)
  );
endmodule

// File: rtl/audio_clk_chk.sv
module audio_clk_chk
  import audio_clk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] div_code,
  input logic       lr_out,
  input logic       bck_out,
  input logic       div_err
);
  logic [FRAME_W-1:0] ck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck <= '0;
    else        ck <= ck + 1'b1;
  end

  a_r4_lr_on_bck_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_out != $past(lr_out)) |-> $fell(bck_out));

  a_r5_frame_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ck == '0) |-> (!lr_out && !bck_out));

  a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == 3'd7) |=> div_err);

  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code != 3'd7) |=> !div_err);
endmodule

bind audio_clk_gen audio_clk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_code(div_code),
  .lr_out(lr_out), .bck_out(bck_out), .div_err(div_err)
);

// File: tb/tb_audio_clk_gen.sv
module tb_audio_clk_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrb_en = 1'b0;
  logic [1:0] lrb_mode = 2'd0;
  logic       mck_en = 1'b0;
  logic       mck_half = 1'b0;
  logic [2:0] div_code = 3'd0;
  logic       lr_out, bck_out, mck_out, div_clk, div_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // model state
  int  n = 0, half = 0, dcnt = 0, dr = 1;
  bit  a_en = 0, a_mck = 0, a_sel = 0;
  int  a_mode = 0;
  bit  prev_lr = 0, prev_bck = 0;

  audio_clk_gen dut (
    .clk(clk), .rst_n(rst_n), .lrb_en(lrb_en), .lrb_mode(lrb_mode),
    .mck_en(mck_en), .mck_half(mck_half), .div_code(div_code),
    .lr_out(lr_out), .bck_out(bck_out), .mck_out(mck_out),
    .div_clk(div_clk), .div_err(div_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: act=%b exp=%b", tag, cycles, act, exp);
    end
  endtask

  function automatic int ratio_of(input int c);
    int r;
    case (c)
      1: r = 2;  2: r = 4;  3: r = 8;  4: r = 16;
      5: r = 3;  6: r = 6;  default: r = 1;
    endcase
    return r;
  endfunction

  // One input cycle: model update at the rising edge, checks in both phases.
  task automatic step();
    int  lr_per, bck_per;
    bit  exp_lr, exp_bck, exp_dq;
    @(posedge clk);
    n = (n + 1) % 256;
    if (n == 0) begin
      a_en = lrb_en; a_mode = lrb_mode; a_mck = mck_en; a_sel = mck_half;
    end
    half ^= 1;
    if (dcnt + 1 >= dr) begin
      dr = ratio_of(div_code); dcnt = 0;
    end else dcnt++;
    lr_per  = (a_mode >= 2) ? 128 : 256;
    bck_per = (a_mode == 0) ? 8 : (a_mode == 3) ? 2 : 4;
    exp_lr  = a_en && ((n % lr_per) >= lr_per / 2);
    exp_bck = a_en && ((n % bck_per) >= bck_per / 2);
    exp_dq  = dcnt < (dr + 1) / 2;
    #1;
    if (a_en) begin
      chk(lr_out, exp_lr, "R2 lr rate");
      chk(bck_out, exp_bck, "R2 bck rate");
    end else begin
      chk(lr_out, 1'b0, "R3 lr off");
      chk(bck_out, 1'b0, "R3 bck off");
    end
    if (n == 0) begin
      chk(lr_out | bck_out, 1'b0, "R5 frame start low");
    end
    if (lr_out != prev_lr) chk(prev_bck & ~bck_out, 1'b1, "R4 lr on bck fall");
    prev_lr = lr_out; prev_bck = bck_out;
    chk(mck_out, a_mck && (a_sel ? half[0] : 1'b1), "R6 mck high phase");
    chk(div_clk, (dr == 1) ? 1'b1 : exp_dq, "R7 R8 R10 div high phase");
    @(negedge clk);
    #1;
    chk(mck_out, a_mck && a_sel && half[0], "R6 mck low phase");
    chk(div_clk, (dr == 1) ? 1'b0 : exp_dq, "R7 R8 R10 div low phase");
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(lr_out, 1'b0, "R1 lr reset");
    chk(bck_out, 1'b0, "R1 bck reset");
    chk(mck_out, 1'b0, "R1 mck reset");
    chk(div_err, 1'b0, "R1 err reset");
    lrb_en = 1'b1; lrb_mode = 2'd2; mck_en = 1'b1; mck_half = 1'b1;
    rst_n = 1'b1;
    // first frame: configuration pending, outputs stay low (R1)
    for (int i = 0; i < 200; i++) begin
      step();
      if (i < 254) chk(lr_out | bck_out | mck_out, 1'b0, "R1 before first frame");
    end
    // sweep configurations, changing them mid-frame; divider codes cycle through all
    for (int cfg = 0; cfg < 16; cfg++) begin
      lrb_mode = cfg[1:0];
      lrb_en   = (cfg % 5) != 4;
      mck_en   = (cfg % 7) != 3;
      mck_half = cfg[2];
      for (int ch = 0; ch < 11; ch++) begin
        div_code = 3'((cfg * 3 + ch) % 8);
        for (int k = 0; k < 37; k++) begin
          step();
          if (k == 0) chk(div_err, div_code == 3'd7, "R9 err flag");
        end
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule